// File: doc/BRIEF.md
# Write-Once Flash Clock Divider

This block holds the 8-bit configuration register that sets the timing clock of a nonvolatile memory controller, together with the clock-enable generator that this register drives. A simple bus port writes and reads the register using a select, a write strobe, write data and read data. The register carries a divisor, a prescale select and a read-only "configured" flag. Only the first selected write after reset is accepted. That write also sets the flag, and the flag opens the erase/program enable output.

Once the flag is set, the generator divides the bus clock and emits a one-bus-cycle `tick`. The tick serves as the clock enable for the program/erase timing logic. The divide ratio is (divisor+1) when the prescale select is 0, and 8×(divisor+1) when it is 1. The divisor should be chosen so that the tick rate falls between 150 kHz and 200 kHz.

The lock is a two-state machine, ST_OPEN → ST_LOCKED:
- The machine leaves reset in ST_OPEN.
- Transition TAKE_WRITE (`sel && wr_en` in ST_OPEN) captures the data and enters ST_LOCKED.
- ST_LOCKED holds until reset through transition HOLD_LOCK.
- ST_OPEN stays where it is through transition WAIT_WRITE while no selected write occurs.

Top module: `nvm_clk_div`

## Requirements
- R1: After reset, a selected read returns 8'h00, `pgm_en` is 0 and `tick` is 0.
- R2: The first write with `sel`=1 and `wr_en`=1 stores wdata[6] as the prescale select and wdata[5:0] as the divisor. It sets the flag at bit 7 whatever the write data holds, wdata[7] included.
- R3: Every write after the first leaves bits 6:0 and the tick timing unchanged.
- R4: A write strobe with `sel`=0 has no effect: the flag stays 0 and `pgm_en` stays 0.
- R5: `pgm_en` is 0 while the flag is 0 and is 1 from the cycle after the accepted write until reset.
- R6: `tick` is never 1 while the flag is 0.
- R7: With prescale select 0 and divisor N, `tick` is first 1 in the (N+1)th cycle after the clock edge that accepts the write, and then repeats every N+1 cycles. With N=0 it is 1 every cycle.
- R8: With prescale select 1 and divisor N, `tick` is first 1 in the 8(N+1)th cycle after the accepting edge, and then repeats every 8(N+1) cycles.
- R9: When the period is greater than 1, each `tick` lasts exactly one cycle.
- R10: With `sel`=1, `rdata` = {flag, prescale, divisor[5:0]} at any time. With `sel`=0, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: {flag, prescale, divisor} |
| tick | output | 1 | One-cycle flash-clock enable |
| pgm_en | output | 1 | Erase/program permitted |

## Verification
A lock state wrongly left in ST_OPEN shows up at the next selected read: a second write changes bits 6:0 at once, and the following tick arrives at the wrong time. A flag that is wrongly set or cleared shows on `pgm_en` and on rdata bit 7 in the very next cycle. A divider or prescaler count that is off by one moves the first tick. The error is visible within one period, so at most 512 cycles for the largest setting, and the bench measures both the first-tick position and the spacing for every table entry.

// File: rtl/nvm_clk_div_pkg.sv
package nvm_clk_div_pkg;
    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/nvm_clk_cfg.sv
module nvm_clk_cfg
    import nvm_clk_div_pkg::*;
#(
    parameter int DIV_W = 6,
    localparam int REG_W = DIV_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic             locked,
    output logic             pre_sel,
    output logic [DIV_W-1:0] div_val
);
    lock_state_e state, state_nxt;
    logic        take;

    assign take = sel && wr_en;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN:   state_nxt = take ? ST_LOCKED : ST_OPEN; // TAKE_WRITE / WAIT_WRITE
            ST_LOCKED: state_nxt = ST_LOCKED;                  // HOLD_LOCK
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_sel <= 1'b0;
            div_val <= '0;
        end else if (state == ST_OPEN && take) begin
            pre_sel <= wdata[DIV_W];
            div_val <= wdata[DIV_W-1:0];
        end
    end

    assign locked = (state == ST_LOCKED);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R5
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(pre_sel) && $stable(div_val))); // R3
    AST_UNSEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !sel) |=> !locked); // R4
endmodule

// File: rtl/nvm_clk_prescale.sv
module nvm_clk_prescale #(
    parameter int PRE_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic pre_sel,
    output logic stage_en
);
    logic pre_tick;

    generate
        if (PRE_LOG2 > 0) begin : g_pre
            logic [PRE_LOG2-1:0] pcnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   pcnt <= '0;
                else if (!run) pcnt <= '0;
                else          pcnt <= pcnt + 1'b1;
            end
            assign pre_tick = run && (pcnt == '1);

            AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                (run && pre_sel && stage_en) |=> !stage_en); // R8
        end else begin : g_nopre
            assign pre_tick = run;
        end
    endgenerate

    assign stage_en = run && (pre_sel ? pre_tick : 1'b1);
endmodule

// File: rtl/nvm_clk_divcnt.sv
module nvm_clk_divcnt #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] dcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dcnt <= '0;
        else if (!run)    dcnt <= '0;
        else if (step)    dcnt <= (dcnt == limit) ? '0 : dcnt + 1'b1;
    end

    assign tick = step && (dcnt == limit);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (dcnt <= limit)); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (dcnt == '0 || run)); // R6
endmodule

// File: rtl/nvm_clk_div.sv
module nvm_clk_div #(
    parameter int DIV_W    = 6,
    parameter int PRE_LOG2 = 3,
    localparam int REG_W   = DIV_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             tick,
    output logic             pgm_en
);
    logic             locked;
    logic             pre_sel;
    logic [DIV_W-1:0] div_val;
    logic             stage_en;

    nvm_clk_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .locked(locked), .pre_sel(pre_sel), .div_val(div_val)
    );

    nvm_clk_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(locked), .pre_sel(pre_sel),
        .stage_en(stage_en)
    );

    nvm_clk_divcnt #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(locked), .step(stage_en),
        .limit(div_val), .tick(tick)
    );

    assign rdata  = sel ? {locked, pre_sel, div_val} : '0;
    assign pgm_en = locked;

    AST_NO_TICK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_en |-> !tick); // R6
    AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rdata == '0)); // R10
endmodule

// File: tb/nvm_clk_div_tb.sv
module nvm_clk_div_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tick;
    logic       pgm_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    nvm_clk_div u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .tick(tick), .pgm_en(pgm_en)
    );

    always #5 clk = ~clk;

    localparam int NVEC = 7;
    localparam logic [7:0] VEC_WR  [NVEC] = '{8'h00, 8'h03, 8'h3F, 8'h40, 8'h41, 8'h7F, 8'hC2};
    localparam logic [7:0] VEC_RD  [NVEC] = '{8'h80, 8'h83, 8'hBF, 8'hC0, 8'hC1, 8'hFF, 8'hC2};
    localparam int         VEC_PER [NVEC] = '{1, 4, 64, 8, 16, 512, 24};

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sel = 1'b0; wr_en = 1'b0; wdata = 8'h00;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic s, input logic [7:0] d);
        sel = s; wr_en = 1'b1; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic read_reg(output logic [7:0] v);
        sel = 1'b1;
        #1 v = rdata;
        sel = 1'b0;
    endtask

    // sample index 0 is the first negedge after the accepting edge
    task automatic measure(input int per, input string tag);
        int first = -1;
        int cnt = 0;
        for (int i = 0; i < 2 * per; i++) begin
            if (tick) begin
                cnt++;
                if (first < 0) first = i;
            end
            @(negedge clk);
        end
        chk({tag, " first tick"}, first, per - 1);
        chk({tag, " ticks in two periods (R9)"}, cnt, 2);
    endtask

    initial begin
        logic [7:0] v;
        // R1, R6: reset state
        do_reset();
        read_reg(v);
        chk("R1 rdata after reset", int'(v), 0);
        chk("R1 pgm_en after reset", int'(pgm_en), 0);
        begin
            int tcnt = 0;
            for (int i = 0; i < 20; i++) begin
                if (tick) tcnt++;
                @(negedge clk);
            end
            chk("R6 no tick while unconfigured", tcnt, 0);
        end
        // R4: strobe without select
        bus_write(1'b0, 8'h45);
        chk("R4 pgm_en after unselected write", int'(pgm_en), 0);
        read_reg(v);
        chk("R4 rdata after unselected write", int'(v), 0);
        chk("R10 rdata with sel low", int'(rdata), 0);

        // vector table: R2, R5, R7, R8, R9, R10
        for (int k = 0; k < NVEC; k++) begin
            do_reset();
            chk("R5 pgm_en before write", int'(pgm_en), 0);
            bus_write(1'b1, VEC_WR[k]);
            chk("R5 pgm_en after write", int'(pgm_en), 1);
            measure(VEC_PER[k], VEC_WR[k][6] ? "R8" : "R7");
            read_reg(v);
            chk("R2/R10 readback", int'(v), int'(VEC_RD[k]));
        end

        // R3: second write ignored, timing unchanged
        do_reset();
        bus_write(1'b1, 8'h02);
        measure(3, "R7 before rewrite");
        bus_write(1'b1, 8'h7F);
        read_reg(v);
        chk("R3 readback after second write", int'(v), 8'h82);
        do_reset();
        bus_write(1'b1, 8'h01);
        bus_write(1'b1, 8'h45);
        // one sample already consumed by the second write: next tick at index 1 -> relative 0
        begin
            int first = -1;
            for (int i = 0; i < 6; i++) begin
                if (tick && first < 0) first = i;
                @(negedge clk);
            end
            chk("R3 tick phase after second write", first, 0);
        end
        read_reg(v);
        chk("R3 readback keeps first value", int'(v), 8'h81);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule